// File: doc/BRIEF.md
# UART Modem Control and Status Unit

This block handles the modem-control side of a single UART channel. A host writes a control register and a modem-status interrupt enable register over an 8-bit data bus with a 3-bit address. A write takes effect when the active-low write strobe returns high. From the control register the block drives the active-low request-to-send pin and a general-purpose user pin. The same control bit decides whether the interrupt pin is actively driven or left floating.

Four active-low modem inputs are sampled: clear-to-send, data-set-ready, ring indicator and carrier detect. Each one passes through a synchronizer. Their current levels and their changes are kept in a status register that the host reads. A modem-status interrupt request is raised while a change is pending and the enable bit is set. Reading the status register clears the pending changes.

A loopback control bit sends the core's transmit data straight back to its receive path. While loopback is on, the transmit pin idles high and the external receive pin is ignored. The block has no streaming data path, so every pin is a plain level or strobe.

Top module: `modem_ctl_unit`

## Requirements
- R1: After reset, rts_n is 1, user_out is 1, irq_out_en is 0, irq_req is 0, loop_sel is 0, and both the control register (address 4) and the status register (address 6) read 0x00 while all modem inputs are high.
- R2: A write is applied when wr_n goes from 0 to 1. It lands in the register selected by addr: 4 is control and 1 is interrupt enable. A write to any other address changes no register or pin.
- R3: rts_n is the inverse of control bit 1.
- R4: When control bit 3 is 1, irq_out_en is 1 and user_out is 0. When the bit is 0, irq_out_en is 0 and user_out is 1.
- R5: When control bit 4 (loopback) is 1, loop_sel is 1, tx_pin is held at 1, rx_to_core follows ser_tx, and rx_pin has no effect. When the bit is 0, tx_pin follows ser_tx and rx_to_core follows rx_pin.
- R6: Status bits 4, 5, 6 and 7 hold the inverted synchronized levels of cts_n, dsr_n, ri_n and dcd_n, in that order.
- R7: Status bits 0, 1 and 3 set on any change of cts_n, dsr_n and dcd_n respectively.
- R8: Status bit 2 sets only when ri_n goes from 0 to 1. A 1-to-0 change of ri_n leaves it clear.
- R9: A read of the status register (rd_en high with addr 6) clears bits 0 to 3 at the next clock edge. A change detected in the same cycle still sets its bit.
- R10: irq_req is 1 exactly when bit 3 of the interrupt enable register is 1 and any of status bits 0 to 3 is set. It stays high until the status register is read or the enable is cleared.
- R11: A modem input change reaches the status register after two clock edges and is not visible after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_n | input | 1 | Write strobe, active low; the write is applied on its release |
| rd_en | input | 1 | Read pulse; a read of address 6 clears the status change bits |
| rdata | output | 8 | Read data for addr (combinational) |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| ser_tx | input | 1 | Serial data from the core's transmitter |
| rx_pin | input | 1 | External receive pin |
| tx_pin | output | 1 | External transmit pin |
| rx_to_core | output | 1 | Serial data to the core's receiver |
| loop_sel | output | 1 | Loopback select |
| rts_n | output | 1 | Request-to-send, active low |
| user_out | output | 1 | User output pin |
| irq_out_en | output | 1 | Output enable for the interrupt pin |
| irq_req | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with the default two-stage synchronizer. With that depth the one-edge and two-edge visibility of R11 can be checked at exact cycles. A scoreboard queues the expected status and control read values and compares each one at the read strobe. These reads cover cases that only appear in sequence: a ring that starts and ends, several lines changing together, a read that clears the change bits, and the enable bit masking a change that is still pending.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int NUM_MODEM = 4;
  localparam logic [ADDR_W-1:0] ADDR_IER = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STS = 3'd6;
  localparam int CTL_RTS  = 1;
  localparam int CTL_PIN  = 3;
  localparam int CTL_LOOP = 4;
  localparam int IER_MS   = 3;
  // index order of modem lines: 0 cts, 1 dsr, 2 ri, 3 dcd
  localparam logic [NUM_MODEM-1:0] RISE_ONLY = 4'b0100;
endpackage

// File: rtl/modem_in_sync.sv
module modem_in_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] sync_n
);
  logic [N-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= pin_n;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
  parameter int N = 4,
  parameter logic [N-1:0] RISE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sync_n,
  input  logic         clr,
  output logic [N-1:0] state,
  output logic [N-1:0] delta
);
  logic [N-1:0] prev_n;
  logic [N-1:0] hit;
  logic [N-1:0] delta_q;

  always_ff @(posedge clk) begin
    if (rst) prev_n <= '1;
    else     prev_n <= sync_n;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    if (RISE_MASK[g]) begin : g_rise
      assign hit[g] = sync_n[g] & ~prev_n[g];
      // R8
      fall_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_n[g] && prev_n[g] && !delta_q[g] && !hit[g]) |=> !delta_q[g]);
    end else begin : g_any
      assign hit[g] = sync_n[g] ^ prev_n[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) delta_q <= '0;
    else     delta_q <= (delta_q & ~{N{clr}}) | hit;
  end

  assign state = ~sync_n;
  assign delta = delta_q;

  // R7
  delta_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((delta_q & $past(hit)) == $past(hit)));
  // R9
  delta_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !(|hit)) |=> (delta_q == '0));
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import modem_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  input  logic              ser_tx,
  input  logic              rx_pin,
  output logic              tx_pin,
  output logic              rx_to_core,
  output logic              loop_sel,
  output logic              rts_n,
  output logic              user_out,
  output logic              irq_out_en,
  output logic              irq_req
);
  logic              wr_n_q;
  logic              wr_fire;
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] ier_q;
  logic [NUM_MODEM-1:0] sync_n;
  logic [NUM_MODEM-1:0] state;
  logic [NUM_MODEM-1:0] delta;
  logic              sts_clr;

  always_ff @(posedge clk) begin
    if (rst) wr_n_q <= 1'b1;
    else     wr_n_q <= wr_n;
  end
  assign wr_fire = wr_n & ~wr_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ier_q <= '0;
    end else if (wr_fire) begin
      if (addr == ADDR_CTL) ctl_q <= wdata;
      if (addr == ADDR_IER) ier_q <= wdata;
    end
  end

  modem_in_sync #(.N(NUM_MODEM), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_n  ({dcd_n, ri_n, dsr_n, cts_n}),
    .sync_n (sync_n)
  );

  assign sts_clr = rd_en && (addr == ADDR_STS);

  modem_delta #(.N(NUM_MODEM), .RISE_MASK(RISE_ONLY)) u_delta (
    .clk    (clk),
    .rst    (rst),
    .sync_n (sync_n),
    .clr    (sts_clr),
    .state  (state),
    .delta  (delta)
  );

  always_comb begin
    case (addr)
      ADDR_CTL: rdata = ctl_q;
      ADDR_IER: rdata = ier_q;
      ADDR_STS: rdata = {state, delta};
      default:  rdata = '0;
    endcase
  end

  assign loop_sel   = ctl_q[CTL_LOOP];
  assign tx_pin     = loop_sel ? 1'b1 : ser_tx;
  assign rx_to_core = loop_sel ? ser_tx : rx_pin;
  assign rts_n      = ~ctl_q[CTL_RTS];
  assign user_out   = ~ctl_q[CTL_PIN];
  assign irq_out_en = ctl_q[CTL_PIN];
  assign irq_req    = ier_q[IER_MS] & (|delta);

  // R3
  rts_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && addr == ADDR_CTL) |=> (rts_n == !$past(wdata[CTL_RTS])));
  // R4
  pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && addr == ADDR_CTL) |=>
      (user_out == !$past(wdata[CTL_PIN]) && irq_out_en == $past(wdata[CTL_PIN])));
  // R2
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_fire && addr == ADDR_CTL) |=> ($stable(rts_n) && $stable(user_out) && $stable(loop_sel)));
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !sts_clr && !(wr_fire && addr == ADDR_IER)) |=> irq_req);
endmodule

// File: tb/tb_modem_ctl_unit.sv
module tb_modem_ctl_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_n = 1'b1, rd_en = 1'b0;
  logic [7:0] rdata;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic ser_tx = 1'b1, rx_pin = 1'b1;
  logic tx_pin, rx_to_core, loop_sel, rts_n, user_out, irq_out_en, irq_req;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  modem_ctl_unit dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_n(wr_n), .rd_en(rd_en),
    .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .ser_tx(ser_tx), .rx_pin(rx_pin), .tx_pin(tx_pin), .rx_to_core(rx_to_core),
    .loop_sel(loop_sel), .rts_n(rts_n), .user_out(user_out),
    .irq_out_en(irq_out_en), .irq_req(irq_req)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    step(1);
    addr = a; wdata = d; wr_n = 1'b0;
    step(1);
    wr_n = 1'b1;
    step(1);
  endtask

  // driver: pushes the expected value, then strobes the read
  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    step(1);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    step(1);
    rd_en = 1'b0;
  endtask

  // monitor: compares at the falling edge of each read cycle
  always @(negedge clk) begin
    if (rd_en) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 8'h01, 8'h00);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 rts_n", rts_n, 1); chk("R1 user_out", user_out, 1);
    chk("R1 irq_out_en", irq_out_en, 0); chk("R1 irq_req", irq_req, 0);
    chk("R1 loop_sel", loop_sel, 0);
    rd(3'd6, 8'h00, "R1 status");
    rd(3'd4, 8'h00, "R1 control");

    wr(3'd4, 8'h02);
    chk("R3 rts_n low", rts_n, 0);
    rd(3'd4, 8'h02, "R2 control write");
    wr(3'd5, 8'hFF);
    chk("R2 stray write rts_n", rts_n, 0);
    chk("R2 stray write user_out", user_out, 1);
    rd(3'd4, 8'h02, "R2 control unchanged");

    wr(3'd4, 8'h0A);
    chk("R4 user_out low", user_out, 0); chk("R4 irq_out_en on", irq_out_en, 1);
    wr(3'd4, 8'h02);
    chk("R4 user_out high", user_out, 1); chk("R4 irq_out_en off", irq_out_en, 0);

    wr(3'd4, 8'h12);
    ser_tx = 1'b0; rx_pin = 1'b1; #1;
    chk("R5 loop tx idle", tx_pin, 1); chk("R5 loop rx", rx_to_core, 0);
    ser_tx = 1'b1; rx_pin = 1'b0; #1;
    chk("R5 loop rx ignores pin", rx_to_core, 1); chk("R5 loop_sel", loop_sel, 1);
    wr(3'd4, 8'h02);
    ser_tx = 1'b0; #1;
    chk("R5 normal tx", tx_pin, 0); chk("R5 normal rx", rx_to_core, 0);
    ser_tx = 1'b1; rx_pin = 1'b1;

    wr(3'd1, 8'h08);
    addr = 3'd6;
    cts_n = 1'b0;
    @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R11 after one edge", {7'd0, rdata[4]}, 0);
    @(posedge clk); @(negedge clk);
    chk("R11 after two edges", {7'd0, rdata[4]}, 1);
    step(3);
    chk("R10 irq on cts change", irq_req, 1);
    rd(3'd6, 8'h11, "R6 R7 cts state and delta");
    step(1);
    chk("R10 irq cleared by read", irq_req, 0);
    rd(3'd6, 8'h10, "R9 delta cleared");

    ri_n = 1'b0;
    step(5);
    chk("R8 ri falling no irq", irq_req, 0);
    rd(3'd6, 8'h50, "R8 ri falling no delta");
    ri_n = 1'b1;
    step(5);
    chk("R8 irq on ri rising", irq_req, 1);
    rd(3'd6, 8'h14, "R8 ri rising delta");

    dsr_n = 1'b0; dcd_n = 1'b0;
    step(5);
    rd(3'd6, 8'hBA, "R6 R7 dsr dcd");
    cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1;
    step(5);
    chk("R10 irq pending", irq_req, 1);
    wr(3'd1, 8'h00);
    chk("R10 irq masked", irq_req, 0);
    wr(3'd1, 8'h08);
    chk("R10 irq unmasked", irq_req, 1);
    rd(3'd6, 8'h0B, "R7 all released");
    rd(3'd6, 8'h00, "R9 cleared");

    step(2);
    chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule